// File: doc/BRIEF.md
# SMBus Host Register Sequencer

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through a small I/O window. Through that window it loads a target address with a direction bit, a command byte, two data bytes and a 32-entry block buffer. It then writes a control byte whose protocol field picks the kind of transfer and whose start bit launches it. The block turns that register state into a single transaction request to a downstream bit-level bus engine.

The block holds the request fields steady while the engine runs. When the engine reports completion, the block copies any read results back into its data registers and sets a done or error flag in status. The engine also has a side port into the block buffer. It uses that port to fetch bytes for block writes and to deposit bytes for block reads.

Software fills and drains the block buffer through one data port. An internal index advances on every access to that port. The index is rewound by a status write or a control read.

Top module: `smbh_seq`

## Requirements
- R1: Only the low 6 address bits are decoded. Offset 0x00 is status, 0x02 control, 0x03 command, 0x04 target address, 0x05 data-low, 0x06 data-high and 0x07 the block data port. Every other offset reads 0x00 and ignores writes.
- R2: A control write with bit 6 set, made while idle, with a supported protocol in bits [4:2], produces exactly one `eng_start` pulse in the next cycle. At that point the request fields show the protocol, target (address bits [7:1]), read flag (address bit 0), command and {data-high, data-low}. Status bit 0 (busy) reads 1 from then until the engine completes.
- R3: Protocol codes 0 (quick), 1 (send/receive byte), 2 (byte data), 3 (word data) and 5 (block) are supported. A start request with code 4, 6 or 7 issues no `eng_start` and sets status bit 2 (error).
- R4: A control write with the start bit set is ignored while busy: no second `eng_start` is issued.
- R5: An `eng_done` pulse while busy clears busy. If `eng_err` is 0 it sets status bit 1 (done). If `eng_err` is 1 it sets status bit 2 and leaves the data registers untouched.
- R6: On a successful read, byte protocols (1, 2) put `eng_rdata[7:0]` in data-low. Word (3) puts the low byte in data-low and the high byte in data-high. Block (5) puts the returned byte count in data-low. Writes capture nothing.
- R7: Any write to status clears the done and error bits and sets the block index to 0.
- R8: Reading control returns bits [4:0] of the last control write, with the upper bits as 0. The same read sets the block index to 0.
- R9: Each read or write of the block data port uses the entry at the current index, then advances the index. After 31 the index goes back to 0.
- R10: The engine reads buffer entry `eng_buf_idx` on `eng_buf_rdata` at any time. It writes that entry with `eng_buf_wdata` when `eng_buf_we` is 1, and an engine write wins over a port write to the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address, low 6 bits decoded |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe (side effects on the block index) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed register |
| eng_start | output | 1 | One-cycle transaction request |
| eng_proto | output | 3 | Protocol code |
| eng_target | output | 7 | 7-bit target address |
| eng_read | output | 1 | 1 = read transfer |
| eng_cmd | output | 8 | Command byte (also the byte sent by send-byte) |
| eng_wdata | output | 16 | {data-high, data-low}; block count in the low byte |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_err | input | 1 | Failure flag, valid with eng_done |
| eng_rdata | input | 16 | Read result, valid with eng_done |
| eng_buf_idx | input | IW | Engine buffer index |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Buffer entry at eng_buf_idx |

## Verification
The hardest situation to reach from the ports is a second start request that lands while a transaction is still outstanding. A close second is a block-port access that crosses the index wrap in the same sequence as a rewind. The bench plays the bus engine itself, so it can hold `eng_done` off for as long as it likes. While the engine is stalled, the bench rewrites control with the start bit and reads status to see busy. It then writes 33 bytes so the index wraps and overwrites entry 0, and rewinds by a control read before draining the buffer.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
   localparam int DW    = 8;
   localparam int DEC_W = 6;

   localparam logic [DEC_W-1:0] OFS_STAT = 6'h00;
   localparam logic [DEC_W-1:0] OFS_CTL  = 6'h02;
   localparam logic [DEC_W-1:0] OFS_CMD  = 6'h03;
   localparam logic [DEC_W-1:0] OFS_TGT  = 6'h04;
   localparam logic [DEC_W-1:0] OFS_DLO  = 6'h05;
   localparam logic [DEC_W-1:0] OFS_DHI  = 6'h06;
   localparam logic [DEC_W-1:0] OFS_BLK  = 6'h07;

   localparam logic [2:0] PR_QUICK = 3'd0;
   localparam logic [2:0] PR_BYTE  = 3'd1;
   localparam logic [2:0] PR_BDATA = 3'd2;
   localparam logic [2:0] PR_WDATA = 3'd3;
   localparam logic [2:0] PR_BLOCK = 3'd5;

   function automatic logic proto_ok(input logic [2:0] p);
      return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
             (p == PR_WDATA) || (p == PR_BLOCK);
   endfunction
endpackage

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf
   import smbh_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          port_we,
   input  logic          port_re,
   input  logic [DW-1:0] port_wdata,
   output logic [DW-1:0] port_rdata,
   input  logic          idx_clr,
   input  logic [IW-1:0] eng_idx,
   input  logic          eng_we,
   input  logic [DW-1:0] eng_wdata,
   output logic [DW-1:0] eng_rdata
);
   initial begin
      if (DEPTH < 2) $error("smbh_blkbuf: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [IW-1:0] idx_q;
   logic [IW-1:0] idx_inc;

   generate
      if ((1 << IW) == DEPTH) begin : g_pow2
         assign idx_inc = idx_q + 1'b1;
      end else begin : g_cmp
         assign idx_inc = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (port_we) mem[idx_q] <= port_wdata;
         if (eng_we)  mem[eng_idx] <= eng_wdata;
         if (idx_clr) idx_q <= '0;
         else if (port_we || port_re) idx_q <= idx_inc;
      end
   end

   assign port_rdata = mem[idx_q];
   assign eng_rdata  = mem[eng_idx];

   // R9: the index goes back to 0 after the last entry
   p_idx_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((port_we || port_re) && !idx_clr && idx_q == IW'(DEPTH - 1)) |=> (idx_q == '0));

   // R7 / R8: a rewind lands on entry 0
   p_idx_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idx_clr |=> (idx_q == '0));
endmodule

// File: rtl/smbh_launch.sv
module smbh_launch
   import smbh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [2:0] proto,
   input  logic       eng_done,
   input  logic       eng_err,
   output logic       busy,
   output logic       start,
   output logic       go_bad,
   output logic       cpl_ok,
   output logic       cpl_err
);
   logic go_ok;

   assign go_ok   = go && !busy && proto_ok(proto);
   assign go_bad  = go && !busy && !proto_ok(proto);
   assign cpl_ok  = eng_done && busy && !eng_err;
   assign cpl_err = eng_done && busy && eng_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         start <= 1'b0;
      end else begin
         start <= go_ok;
         if (go_ok) busy <= 1'b1;
         else if (eng_done && busy) busy <= 1'b0;
      end
   end

   // R2: a request is a single pulse and busy is already up when it appears
   p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> busy);
   // R4: a start while busy produces no request
   p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && busy) |=> !start);
   // R3: an unsupported code produces no request
   p_badproto_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go_bad |=> (!start && !busy));
   // R5: completion drops busy
   p_cpl_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && busy) |=> !busy);
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
   import smbh_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUF_DEPTH = 32,
   localparam int IW = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              eng_start,
   output logic [2:0]        eng_proto,
   output logic [6:0]        eng_target,
   output logic              eng_read,
   output logic [7:0]        eng_cmd,
   output logic [15:0]       eng_wdata,
   input  logic              eng_done,
   input  logic              eng_err,
   input  logic [15:0]       eng_rdata,
   input  logic [IW-1:0]     eng_buf_idx,
   input  logic              eng_buf_we,
   input  logic [7:0]        eng_buf_wdata,
   output logic [7:0]        eng_buf_rdata
);
   initial begin
      if (ADDR_W < DEC_W) $error("smbh_seq: ADDR_W must cover the decoded offset");
   end

   logic [DEC_W-1:0] ofs;
   logic wr_stat, wr_ctl, wr_cmd, wr_tgt, wr_dlo, wr_dhi, wr_blk, rd_ctl, rd_blk;
   logic [4:0] ctl_q;
   logic [7:0] cmd_q, tgt_q, dlo_q, dhi_q;
   logic       done_q, err_q;
   logic       busy, go_bad, cpl_ok, cpl_err;
   logic [7:0] blk_rdata;

   assign ofs     = io_addr[DEC_W-1:0];
   assign wr_stat = io_wr && ofs == OFS_STAT;
   assign wr_ctl  = io_wr && ofs == OFS_CTL;
   assign wr_cmd  = io_wr && ofs == OFS_CMD;
   assign wr_tgt  = io_wr && ofs == OFS_TGT;
   assign wr_dlo  = io_wr && ofs == OFS_DLO;
   assign wr_dhi  = io_wr && ofs == OFS_DHI;
   assign wr_blk  = io_wr && ofs == OFS_BLK;
   assign rd_ctl  = io_rd && ofs == OFS_CTL;
   assign rd_blk  = io_rd && ofs == OFS_BLK;

   smbh_launch u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (wr_ctl && io_wdata[6]),
      .proto    (io_wdata[4:2]),
      .eng_done (eng_done),
      .eng_err  (eng_err),
      .busy     (busy),
      .start    (eng_start),
      .go_bad   (go_bad),
      .cpl_ok   (cpl_ok),
      .cpl_err  (cpl_err)
   );

   smbh_blkbuf #(.DEPTH(BUF_DEPTH)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_we    (wr_blk),
      .port_re    (rd_blk),
      .port_wdata (io_wdata),
      .port_rdata (blk_rdata),
      .idx_clr    (wr_stat || rd_ctl),
      .eng_idx    (eng_buf_idx),
      .eng_we     (eng_buf_we),
      .eng_wdata  (eng_buf_wdata),
      .eng_rdata  (eng_buf_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cmd_q  <= '0;
         tgt_q  <= '0;
         dlo_q  <= '0;
         dhi_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (wr_ctl) ctl_q <= io_wdata[4:0];
         if (wr_cmd) cmd_q <= io_wdata;
         if (wr_tgt) tgt_q <= io_wdata;
         if (wr_dlo) dlo_q <= io_wdata;
         if (wr_dhi) dhi_q <= io_wdata;
         if (cpl_ok && tgt_q[0]) begin
            case (ctl_q[4:2])
               PR_BYTE, PR_BDATA, PR_BLOCK: dlo_q <= eng_rdata[7:0];
               PR_WDATA: begin
                  dlo_q <= eng_rdata[7:0];
                  dhi_q <= eng_rdata[15:8];
               end
               default: ;
            endcase
         end
         if (wr_stat) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
         end
         if (cpl_ok) done_q <= 1'b1;
         if (go_bad || cpl_err) err_q <= 1'b1;
      end
   end

   always_comb begin
      case (ofs)
         OFS_STAT: io_rdata = {5'b0, err_q, done_q, busy};
         OFS_CTL:  io_rdata = {3'b0, ctl_q};
         OFS_CMD:  io_rdata = cmd_q;
         OFS_TGT:  io_rdata = tgt_q;
         OFS_DLO:  io_rdata = dlo_q;
         OFS_DHI:  io_rdata = dhi_q;
         OFS_BLK:  io_rdata = blk_rdata;
         default:  io_rdata = 8'h00;
      endcase
   end

   assign eng_proto  = ctl_q[4:2];
   assign eng_target = tgt_q[7:1];
   assign eng_read   = tgt_q[0];
   assign eng_cmd    = cmd_q;
   assign eng_wdata  = {dhi_q, dlo_q};

   // R7: a status write leaves done and error clear
   p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !cpl_ok && !cpl_err) |=> (!done_q && !err_q));
   // R5: a failed completion raises the error flag and keeps data-low
   p_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_err && !wr_dlo) |=> (err_q && $stable(dlo_q)));
   // R3: an unsupported code raises the error flag
   p_bad_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go_bad |=> err_q);
   // R6: a word read returns its high byte in data-high
   p_word_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_ok && tgt_q[0] && ctl_q[4:2] == PR_WDATA) |=> (dhi_q == $past(eng_rdata[15:8])));
endmodule

// File: tb/sim_smbh_seq.sv
module sim_smbh_seq;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] io_addr = '0;
   logic io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic eng_start, eng_read;
   logic [2:0] eng_proto;
   logic [6:0] eng_target;
   logic [7:0] eng_cmd;
   logic [15:0] eng_wdata;
   logic eng_done = 1'b0, eng_err = 1'b0;
   logic [15:0] eng_rdata = '0;
   logic [4:0] eng_buf_idx = '0;
   logic eng_buf_we = 1'b0;
   logic [7:0] eng_buf_wdata = '0;
   logic [7:0] eng_buf_rdata;

   int tests = 0, fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smbh_seq u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .eng_start(eng_start),
      .eng_proto(eng_proto), .eng_target(eng_target), .eng_read(eng_read),
      .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .eng_done(eng_done),
      .eng_err(eng_err), .eng_rdata(eng_rdata), .eng_buf_idx(eng_buf_idx),
      .eng_buf_we(eng_buf_we), .eng_buf_wdata(eng_buf_wdata),
      .eng_buf_rdata(eng_buf_rdata)
   );

   // behavioural reference model
   bit m_busy, m_done, m_err, m_start;
   logic [4:0] m_ctl;
   logic [7:0] m_cmd, m_tgt, m_dlo, m_dhi;
   logic [7:0] m_buf [DEPTH];
   int m_idx;

   function automatic bit ok_code(input int p);
      return p == 0 || p == 1 || p == 2 || p == 3 || p == 5;
   endfunction

   function automatic logic [7:0] m_read(input logic [7:0] a);
      case (a % 64)
         0: return {5'b0, m_err, m_done, m_busy};
         2: return {3'b0, m_ctl};
         3: return m_cmd;
         4: return m_tgt;
         5: return m_dlo;
         6: return m_dhi;
         7: return m_buf[m_idx];
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_err = 0; m_start = 0;
         m_ctl = 0; m_cmd = 0; m_tgt = 0; m_dlo = 0; m_dhi = 0; m_idx = 0;
         for (int i = 0; i < DEPTH; i++) m_buf[i] = 0;
      end else begin
         bit was_busy, nstart;
         was_busy = m_busy; nstart = 0;
         if (io_wr) begin
            case (io_addr % 64)
               0: begin m_done = 0; m_err = 0; m_idx = 0; end
               2: begin
                  m_ctl = io_wdata[4:0];
                  if (io_wdata[6] && !was_busy) begin
                     if (ok_code(int'(io_wdata[4:2]))) begin m_busy = 1; nstart = 1; end
                     else m_err = 1;
                  end
               end
               3: m_cmd = io_wdata;
               4: m_tgt = io_wdata;
               5: m_dlo = io_wdata;
               6: m_dhi = io_wdata;
               7: begin m_buf[m_idx] = io_wdata; m_idx = (m_idx + 1) % DEPTH; end
               default: ;
            endcase
         end
         if (eng_buf_we) m_buf[eng_buf_idx] = eng_buf_wdata;
         if (io_rd) begin
            if (io_addr % 64 == 2) m_idx = 0;
            else if (io_addr % 64 == 7) m_idx = (m_idx + 1) % DEPTH;
         end
         if (eng_done && was_busy) begin
            m_busy = 0;
            if (eng_err) m_err = 1;
            else begin
               m_done = 1;
               if (m_tgt[0]) begin
                  if (m_ctl[4:2] == 3) begin m_dlo = eng_rdata[7:0]; m_dhi = eng_rdata[15:8]; end
                  else if (m_ctl[4:2] == 1 || m_ctl[4:2] == 2 || m_ctl[4:2] == 5)
                     m_dlo = eng_rdata[7:0];
               end
            end
         end
         m_start = nstart;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   // R2 R3 R4: request pulse compared against the model every cycle
   always @(negedge clk) begin
      if (rst_n && !finished) chk("R2/R3/R4 eng_start", eng_start, m_start);
   end

   task automatic io_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input string tag, input logic [7:0] a);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 chk(tag, io_rdata, m_read(a));
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic engine(input logic [2:0] p, input logic [6:0] t, input logic rd,
                         input logic [7:0] c, input logic [15:0] wd,
                         input logic e, input logic [15:0] rdv);
      chk("R2 eng_proto", eng_proto, p);
      chk("R2 eng_target", eng_target, t);
      chk("R2 eng_read", eng_read, rd);
      chk("R2 eng_cmd", eng_cmd, c);
      chk("R2 eng_wdata", eng_wdata, wd);
      @(negedge clk);
      eng_done = 1'b1; eng_err = e; eng_rdata = rdv;
      @(negedge clk);
      eng_done = 1'b0; eng_err = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state and decode
      io_read("R1 status reset", 8'h00);
      io_read("R8 control reset", 8'h02);
      io_write(8'h01, 8'hFF);
      io_write(8'h3F, 8'hFF);
      io_read("R1 unlisted 01", 8'h01);
      io_read("R1 unlisted 3F", 8'h3F);
      io_write(8'h43, 8'h5A);            // aliases offset 0x03
      io_read("R1 alias cmd", 8'h03);
      io_read("R1 status after junk", 8'h00);

      // word read with a start retried while busy
      io_write(8'h03, 8'hA5);
      io_write(8'h04, 8'h51);
      io_write(8'h02, 8'h4C);
      io_read("R2 busy set", 8'h00);
      io_write(8'h02, 8'h4C);            // R4 ignored while busy
      io_read("R4 still busy", 8'h00);
      engine(3'd3, 7'h28, 1'b1, 8'hA5, 16'h0000, 1'b0, 16'hBEEF);
      io_read("R5 done flag", 8'h00);
      io_read("R6 word low", 8'h05);
      io_read("R6 word high", 8'h06);
      io_read("R8 control low bits", 8'h02);
      io_write(8'h00, 8'h00);
      io_read("R7 status cleared", 8'h00);

      // word write: nothing captured
      io_write(8'h04, 8'h50);
      io_write(8'h05, 8'h34);
      io_write(8'h06, 8'h12);
      io_write(8'h02, 8'h4C);
      engine(3'd3, 7'h28, 1'b0, 8'hA5, 16'h1234, 1'b0, 16'hFFFF);
      io_read("R6 write keeps low", 8'h05);
      io_write(8'h00, 8'h00);

      // unsupported codes
      io_write(8'h02, 8'h50);
      io_read("R3 code 4 error", 8'h00);
      io_write(8'h00, 8'h00);
      io_write(8'h02, 8'h5C);
      io_read("R3 code 7 error", 8'h00);
      io_write(8'h00, 8'h00);

      // engine failure on a byte-data read
      io_write(8'h04, 8'h61);
      io_write(8'h02, 8'h48);
      engine(3'd2, 7'h30, 1'b1, 8'hA5, 16'h1234, 1'b1, 16'h0077);
      io_read("R5 error flag", 8'h00);
      io_read("R5 data kept", 8'h05);
      io_write(8'h00, 8'h00);

      // receive byte and quick command
      io_write(8'h02, 8'h44);
      engine(3'd1, 7'h30, 1'b1, 8'hA5, 16'h1234, 1'b0, 16'h00C3);
      io_read("R6 receive byte", 8'h05);
      io_write(8'h04, 8'h60);
      io_write(8'h02, 8'h40);
      engine(3'd0, 7'h30, 1'b0, 8'hA5, 16'h12C3, 1'b0, 16'h0099);
      io_read("R6 quick no capture", 8'h05);
      io_write(8'h00, 8'h00);

      // block port: 33 writes wrap and overwrite entry 0
      for (int i = 0; i < 33; i++) io_write(8'h07, 8'(8'h10 + i));
      io_read("R9 index after wrap", 8'h07);
      io_read("R8 control rewinds", 8'h02);
      for (int i = 0; i < DEPTH; i++) io_read("R9 block readback", 8'h07);
      io_read("R9 read wrapped", 8'h07);

      // block write: engine fetches bytes from index 0
      io_write(8'h00, 8'h00);
      io_write(8'h05, 8'h04);
      io_write(8'h04, 8'h22);
      io_write(8'h02, 8'h54);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         eng_buf_idx = 5'(i);
         #1 chk("R10 engine fetch", eng_buf_rdata, m_buf[i]);
      end
      engine(3'd5, 7'h11, 1'b0, 8'hA5, 16'h1204, 1'b0, 16'h0000);

      // block read: engine deposits 3 bytes and returns the count
      io_write(8'h04, 8'h23);
      io_write(8'h02, 8'h54);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         eng_buf_idx = 5'(i); eng_buf_wdata = 8'(8'hE0 + i); eng_buf_we = 1'b1;
      end
      @(negedge clk);
      eng_buf_we = 1'b0;
      engine(3'd5, 7'h11, 1'b1, 8'hA5, 16'h1204, 1'b0, 16'h0003);
      io_read("R6 block count", 8'h05);
      io_read("R8 rewind", 8'h02);
      for (int i = 0; i < 4; i++) io_read("R10 deposited bytes", 8'h07);

      // R10 engine write beats a port write to the same entry
      io_read("R8 rewind again", 8'h02);
      @(negedge clk);
      io_addr = 8'h07; io_wdata = 8'h55; io_wr = 1'b1;
      eng_buf_idx = 5'd0; eng_buf_wdata = 8'hAA; eng_buf_we = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; eng_buf_we = 1'b0;
      #1 chk("R10 engine priority", eng_buf_rdata, 8'hAA);
      io_read("R10 model agrees", 8'h02);
      io_read("R10 entry 0", 8'h07);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule